// File: doc/BRIEF.md
# Automatic UART Flow Controller

This block sits between a UART's receive deserializer, its two FIFOs and its transmit shifter. It applies flow control in both directions. Two methods can run at once: character-based (XON/XOFF) and handshake-line based (RTS/CTS and DTR/DSR). On the receive side it watches the receive-FIFO fill level against a programmable high mark and low mark, with hysteresis between them. When the level reaches the high mark it asks the far end to stop: it raises the enabled handshake outputs and, if character control is on, queues one XOFF. When the level drains to the low mark it releases the handshake outputs and queues one XON.

On the transmit side it decides which byte the shifter loads next. A queued XON/XOFF goes ahead of the next FIFO byte. FIFO bytes are held back while the far end has sent XOFF, or while an enabled CTS or DSR input is inactive. A load only ever happens while the shifter is idle, so a character being shifted always completes. Received characters are sorted as they arrive. With character control on, XON and XOFF characters are consumed and change the pause state. All other characters are passed on for writing into the receive FIFO. Any received character equal to a programmable special value raises a one-cycle event.

Handshake lines are active-low at the ports: a low level means "asserted / go".

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, `rts_n` and `dtr_n` are low, `st_rx_stopped`, `st_tx_paused` and `spec_hit` are low, and no control character is queued.
- R2: The receive stop state is set one clock after `rx_level >= cfg_hi_lvl` while clear. It is cleared one clock after `rx_level <= cfg_lo_lvl` while set. Levels strictly between the marks leave it unchanged.
- R3: `rts_n` is high exactly when `cfg_rtscts_en` is 1 and the stop state is set. `dtr_n` is high exactly when `cfg_dtrdsr_en` is 1 and the stop state is set. A disabled pair drives its output low.
- R4: With `cfg_inband_en` = 1, entering the stop state queues one XOFF and leaving it queues one XON. A newly queued character replaces one that has not yet been sent, and each queued character is sent once.
- R5: A queued control character is presented on `sh_data` with `sh_load` = 1 and `txf_pop` = 0 as soon as `sh_busy` is 0. It takes priority over FIFO data and is sent even while transmission is held.
- R6: A FIFO byte is loaded (`sh_load` = 1, `sh_data` = `txf_data`, `txf_pop` = 1) only when `sh_busy` = 0, `txf_valid` = 1, nothing is queued and transmission is not held. `sh_load` is never 1 while `sh_busy` = 1.
- R7: Transmission is held when the in-band pause is set, or when `cfg_rtscts_en` = 1 and `cts_n` = 1, or when `cfg_dtrdsr_en` = 1 and `dsr_n` = 1. A disabled pair's input has no effect.
- R8: With `cfg_inband_en` = 1, a received character equal to `cfg_xoff_char` sets the pause and one equal to `cfg_xon_char` clears it (XOFF wins if both match). Neither is passed on (`rxc_push` = 0). Every other valid character is passed on. With `cfg_inband_en` = 0, all characters are passed on and the pause is cleared.
- R9: `spec_hit` is 1 for exactly the cycle after a valid received character equal to `cfg_spec_char` while `cfg_spec_en` = 1.
- R10: `st_rx_stopped` shows the stop state, `st_tx_paused` shows the in-band pause, and `st_tx_hold` shows the combined transmit hold of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_inband_en | input | 1 | Enable XON/XOFF control |
| cfg_rtscts_en | input | 1 | Enable RTS/CTS pair |
| cfg_dtrdsr_en | input | 1 | Enable DTR/DSR pair |
| cfg_spec_en | input | 1 | Enable special-character event |
| cfg_xon_char | input | 8 | XON character value |
| cfg_xoff_char | input | 8 | XOFF character value |
| cfg_spec_char | input | 8 | Special character value |
| cfg_hi_lvl | input | 8 | Stop mark for receive level |
| cfg_lo_lvl | input | 8 | Release mark for receive level |
| rx_level | input | 8 | Receive FIFO fill level |
| rxc_valid | input | 1 | Received character strobe |
| rxc_data | input | 8 | Received character |
| rxc_push | output | 1 | Write received character into receive FIFO |
| spec_hit | output | 1 | Special character received (one-cycle pulse) |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| txf_valid | input | 1 | Transmit FIFO not empty |
| txf_data | input | 8 | Transmit FIFO head byte |
| txf_pop | output | 1 | Remove head byte from transmit FIFO |
| sh_busy | input | 1 | Transmit shifter busy with a character |
| sh_load | output | 1 | Load shifter this cycle |
| sh_data | output | 8 | Byte loaded into shifter |
| st_rx_stopped | output | 1 | Receive stop state |
| st_tx_paused | output | 1 | In-band pause from far end |
| st_tx_hold | output | 1 | Combined transmit hold |

## Verification
A stop state stuck on the wrong side of the marks shows one clock later as a wrong `rts_n`/`dtr_n` level and `st_rx_stopped` value. A queue slot that is lost, doubled or wrong shows on the first idle shifter cycle: the `sh_data` byte or the `txf_pop` strobe is wrong. A wrong pause state shows either as a FIFO load that should have been held or as a missing load, on the first idle cycle after the XON/XOFF that caused it. Control characters leaking into the receive FIFO show at once on `rxc_push`.

// File: rtl/flow_pkg.sv
// Shared types for the UART flow controller.
// Assumes: one control character can be pending at a time.
package flow_pkg;
    typedef enum logic [1:0] {
        CTL_NONE = 2'd0,
        CTL_XON  = 2'd1,
        CTL_XOFF = 2'd2
    } ctl_kind_e;
endpackage

// File: rtl/flow_rx_watch.sv
// Receive-level watcher: hysteresis stop state plus a one-deep control
// character queue. Assumes the high mark is above the low mark.
module flow_rx_watch
    import flow_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inband_en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] hi_lvl,
    input  logic [LVL_W-1:0] lo_lvl,
    input  logic             ctl_sent,
    output logic             stopped,
    output ctl_kind_e        pend
);

    logic go_stop;
    logic go_free;

    // Decide threshold crossings against the current state.
    always_comb begin
        go_stop = !stopped && (level >= hi_lvl);
        go_free = stopped && (level <= lo_lvl);
    end

    // Update stop state and the pending control character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped <= 1'b0;
            pend    <= CTL_NONE;
        end else begin
            if (ctl_sent) pend <= CTL_NONE;
            if (go_stop) begin
                stopped <= 1'b1;
                pend    <= CTL_XOFF;
            end else if (go_free) begin
                stopped <= 1'b0;
                pend    <= CTL_XON;
            end
            if (!inband_en) pend <= CTL_NONE;
        end
    end

    AST_STOP_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && level >= hi_lvl) |=> stopped); // R2
    AST_FREE_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && level <= lo_lvl) |=> !stopped); // R2
    AST_XOFF_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stopped) && $past(inband_en) && inband_en) |-> pend == CTL_XOFF); // R4

endmodule

// File: rtl/flow_char_sort.sv
// Received-character sorter: consumes XON/XOFF when in-band control is on,
// keeps the in-band pause state and flags the special character.
// Assumes rxc_valid is a single-cycle strobe per character.
module flow_char_sort #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inband_en,
    input  logic              spec_en,
    input  logic [CHAR_W-1:0] xon_char,
    input  logic [CHAR_W-1:0] xoff_char,
    input  logic [CHAR_W-1:0] spec_char,
    input  logic              rxc_valid,
    input  logic [CHAR_W-1:0] rxc_data,
    output logic              rxc_push,
    output logic              paused,
    output logic              spec_hit
);

    logic is_xoff;
    logic is_xon;

    // Classify the incoming character; XOFF wins on equal values.
    always_comb begin
        is_xoff  = inband_en && (rxc_data == xoff_char);
        is_xon   = inband_en && !is_xoff && (rxc_data == xon_char);
        rxc_push = rxc_valid && !is_xoff && !is_xon;
    end

    // Track far-end pause requests.
    always_ff @(posedge clk) begin
        if (!rst_n)                   paused <= 1'b0;
        else if (!inband_en)          paused <= 1'b0;
        else if (rxc_valid && is_xoff) paused <= 1'b1;
        else if (rxc_valid && is_xon)  paused <= 1'b0;
    end

    // One-cycle special-character event.
    always_ff @(posedge clk) begin
        if (!rst_n) spec_hit <= 1'b0;
        else        spec_hit <= rxc_valid && spec_en && (rxc_data == spec_char);
    end

    AST_PUSH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rxc_push |-> rxc_valid); // R8
    AST_XOFF_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (rxc_valid && inband_en && rxc_data == xoff_char) |=> (paused || !inband_en)); // R8
    AST_SPEC_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
        spec_hit |-> $past(rxc_valid)); // R9

endmodule

// File: rtl/flow_tx_gate.sv
// Transmit gate: combines pause sources and picks the next shifter byte.
// Assumes the shifter samples sh_data when sh_load is high and it is idle.
module flow_tx_gate
    import flow_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paused,
    input  logic              rtscts_en,
    input  logic              cts_n,
    input  logic              dtrdsr_en,
    input  logic              dsr_n,
    input  ctl_kind_e         pend,
    input  logic [CHAR_W-1:0] xon_char,
    input  logic [CHAR_W-1:0] xoff_char,
    input  logic              txf_valid,
    input  logic [CHAR_W-1:0] txf_data,
    input  logic              sh_busy,
    output logic              hold,
    output logic              sh_load,
    output logic [CHAR_W-1:0] sh_data,
    output logic              txf_pop,
    output logic              ctl_sent
);

    // Select control character first, then FIFO data when not held.
    always_comb begin
        hold     = paused || (rtscts_en && cts_n) || (dtrdsr_en && dsr_n);
        ctl_sent = !sh_busy && (pend != CTL_NONE);
        txf_pop  = !sh_busy && (pend == CTL_NONE) && txf_valid && !hold;
        sh_load  = ctl_sent || txf_pop;
        if (pend == CTL_XOFF)     sh_data = xoff_char;
        else if (pend == CTL_XON) sh_data = xon_char;
        else                      sh_data = txf_data;
    end

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sh_load |-> !sh_busy); // R6
    AST_HOLD_BLOCKS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !txf_pop); // R7
    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        txf_pop |-> (txf_valid && sh_load)); // R6
    AST_CTL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sent |-> !txf_pop); // R5

endmodule

// File: rtl/uart_flow_ctrl.sv
// Top of the UART flow controller: in-band and handshake-line control
// in both directions. Handshake lines are active-low at the ports.
module uart_flow_ctrl
    import flow_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_inband_en,
    input  logic              cfg_rtscts_en,
    input  logic              cfg_dtrdsr_en,
    input  logic              cfg_spec_en,
    input  logic [CHAR_W-1:0] cfg_xon_char,
    input  logic [CHAR_W-1:0] cfg_xoff_char,
    input  logic [CHAR_W-1:0] cfg_spec_char,
    input  logic [LVL_W-1:0]  cfg_hi_lvl,
    input  logic [LVL_W-1:0]  cfg_lo_lvl,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rxc_valid,
    input  logic [CHAR_W-1:0] rxc_data,
    output logic              rxc_push,
    output logic              spec_hit,
    input  logic              cts_n,
    input  logic              dsr_n,
    output logic              rts_n,
    output logic              dtr_n,
    input  logic              txf_valid,
    input  logic [CHAR_W-1:0] txf_data,
    output logic              txf_pop,
    input  logic              sh_busy,
    output logic              sh_load,
    output logic [CHAR_W-1:0] sh_data,
    output logic              st_rx_stopped,
    output logic              st_tx_paused,
    output logic              st_tx_hold
);

    logic      stopped;
    logic      paused;
    logic      hold;
    logic      ctl_sent;
    ctl_kind_e pend;

    flow_rx_watch #(.LVL_W(LVL_W)) i_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .inband_en(cfg_inband_en),
        .level    (rx_level),
        .hi_lvl   (cfg_hi_lvl),
        .lo_lvl   (cfg_lo_lvl),
        .ctl_sent (ctl_sent),
        .stopped  (stopped),
        .pend     (pend)
    );

    flow_char_sort #(.CHAR_W(CHAR_W)) i_sort (
        .clk      (clk),
        .rst_n    (rst_n),
        .inband_en(cfg_inband_en),
        .spec_en  (cfg_spec_en),
        .xon_char (cfg_xon_char),
        .xoff_char(cfg_xoff_char),
        .spec_char(cfg_spec_char),
        .rxc_valid(rxc_valid),
        .rxc_data (rxc_data),
        .rxc_push (rxc_push),
        .paused   (paused),
        .spec_hit (spec_hit)
    );

    flow_tx_gate #(.CHAR_W(CHAR_W)) i_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .paused   (paused),
        .rtscts_en(cfg_rtscts_en),
        .cts_n    (cts_n),
        .dtrdsr_en(cfg_dtrdsr_en),
        .dsr_n    (dsr_n),
        .pend     (pend),
        .xon_char (cfg_xon_char),
        .xoff_char(cfg_xoff_char),
        .txf_valid(txf_valid),
        .txf_data (txf_data),
        .sh_busy  (sh_busy),
        .hold     (hold),
        .sh_load  (sh_load),
        .sh_data  (sh_data),
        .txf_pop  (txf_pop),
        .ctl_sent (ctl_sent)
    );

    // Drive handshake outputs and status from internal state.
    always_comb begin
        rts_n         = cfg_rtscts_en && stopped;
        dtr_n         = cfg_dtrdsr_en && stopped;
        st_rx_stopped = stopped;
        st_tx_paused  = paused;
        st_tx_hold    = hold;
    end

    AST_RTS_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rtscts_en |-> !rts_n); // R3
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!rts_n && !dtr_n && !st_tx_paused)); // R1

endmodule

// File: tb/test_uart_flow_ctrl.sv
module test_uart_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_inband_en = 0, cfg_rtscts_en = 0, cfg_dtrdsr_en = 0, cfg_spec_en = 0;
    logic [7:0] cfg_xon_char = 8'h11, cfg_xoff_char = 8'h13, cfg_spec_char = 8'h7E;
    logic [7:0] cfg_hi_lvl = 8'd100, cfg_lo_lvl = 8'd20, rx_level = 8'd0;
    logic       rxc_valid = 0;
    logic [7:0] rxc_data = 0;
    logic       cts_n = 0, dsr_n = 0, txf_valid = 0, sh_busy = 0;
    logic [7:0] txf_data = 8'hA5;
    logic       rxc_push, spec_hit, rts_n, dtr_n, txf_pop, sh_load;
    logic [7:0] sh_data;
    logic       st_rx_stopped, st_tx_paused, st_tx_hold;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_flow_ctrl i_uart_flow_ctrl (.*);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // {inband, data[7:0], exp_push, exp_paused}
    localparam int NV = 7;
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 8'h13, 1'b0, 1'b1},
        {1'b1, 8'h41, 1'b1, 1'b1},
        {1'b1, 8'h11, 1'b0, 1'b0},
        {1'b1, 8'h41, 1'b1, 1'b0},
        {1'b0, 8'h13, 1'b1, 1'b0},
        {1'b1, 8'h13, 1'b0, 1'b1},
        {1'b1, 8'h11, 1'b0, 1'b0}
    };

    initial begin
        #(20 * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R1 rts_n", rts_n, 0);
        chk("R1 dtr_n", dtr_n, 0);
        rst_n = 1'b1;
        cfg_rtscts_en = 1; cfg_dtrdsr_en = 1; cfg_inband_en = 1;
        tick();
        chk("R1 rts_n", rts_n, 0);
        chk("R1 dtr_n", dtr_n, 0);
        chk("R1 stopped", st_rx_stopped, 0);
        chk("R1 paused", st_tx_paused, 0);
        chk("R1 spec", spec_hit, 0);
        chk("R1 no queued ctl", sh_load, 0);
        cfg_rtscts_en = 0; cfg_dtrdsr_en = 0;

        // R8 receive character table
        for (int i = 0; i < NV; i++) begin
            cfg_inband_en = VEC[i][10];
            rxc_data = VEC[i][9:2];
            rxc_valid = 1;
            #2;
            chk("R8 push", rxc_push, VEC[i][1]);
            tick();
            rxc_valid = 0;
            #2;
            chk("R8 R10 paused", st_tx_paused, VEC[i][0]);
            @(negedge clk);
        end

        // R2 R3 hysteresis on RTS, then DTR
        cfg_inband_en = 0; cfg_rtscts_en = 1;
        rx_level = 99;  tick(); chk("R2 below high", rts_n, 0);
        rx_level = 100; tick(); chk("R2 R3 at high", rts_n, 1);
        chk("R10 stopped", st_rx_stopped, 1);
        chk("R3 dtr disabled", dtr_n, 0);
        rx_level = 50;  tick(); chk("R2 between", rts_n, 1);
        rx_level = 21;  tick(); chk("R2 above low", rts_n, 1);
        rx_level = 20;  tick(); chk("R2 at low", rts_n, 0);
        cfg_rtscts_en = 0; cfg_dtrdsr_en = 1;
        rx_level = 128; tick(); chk("R3 dtr", dtr_n, 1);
        chk("R3 rts disabled", rts_n, 0);
        rx_level = 0;   tick(); chk("R3 dtr release", dtr_n, 0);
        cfg_dtrdsr_en = 0;

        // R4 R5 R6 queue ordering and character boundary
        cfg_inband_en = 1; sh_busy = 1; txf_valid = 1; txf_data = 8'hA5;
        rx_level = 100; tick();
        chk("R5 busy no load", sh_load, 0);
        chk("R6 busy no pop", txf_pop, 0);
        sh_busy = 0; #2;
        chk("R5 xoff load", sh_load, 1);
        chk("R4 R5 xoff data", sh_data, 8'h13);
        chk("R5 ctl no pop", txf_pop, 0);
        tick();
        chk("R4 sent once", sh_data, 8'hA5);
        chk("R6 fifo pop", txf_pop, 1);
        sh_busy = 1;
        rx_level = 0;   tick();
        rx_level = 100; tick();
        rx_level = 0;   tick();
        sh_busy = 0; #2;
        chk("R4 replaced by xon", sh_data, 8'h11);
        chk("R5 ctl no pop", txf_pop, 0);
        tick();
        chk("R4 one xon only", txf_pop, 1);

        // R7 hold sources
        cfg_rtscts_en = 1; cts_n = 1; #2;
        chk("R7 cts hold", sh_load, 0);
        chk("R10 hold", st_tx_hold, 1);
        cts_n = 0; #2; chk("R7 cts go", txf_pop, 1);
        cfg_dtrdsr_en = 1; dsr_n = 1; #2; chk("R7 dsr hold", sh_load, 0);
        dsr_n = 0; #2; chk("R7 dsr go", sh_load, 1);
        cfg_rtscts_en = 0; cfg_dtrdsr_en = 0; cts_n = 1; dsr_n = 1; #2;
        chk("R7 disabled pair ignored", txf_pop, 1);
        cts_n = 0; dsr_n = 0;
        rxc_data = 8'h13; rxc_valid = 1; tick(); rxc_valid = 0; #2;
        chk("R7 inband hold", txf_pop, 0);
        chk("R10 hold inband", st_tx_hold, 1);
        @(negedge clk);
        rx_level = 100; tick();
        chk("R5 ctl sent while held", sh_load, 1);
        chk("R5 ctl data", sh_data, 8'h13);
        tick();
        chk("R7 held after ctl", sh_load, 0);
        rx_level = 0; tick(); tick();
        rxc_data = 8'h11; rxc_valid = 1; tick(); rxc_valid = 0; #2;
        chk("R7 resume on xon", txf_pop, 1);
        @(negedge clk);
        txf_valid = 0;

        // R9 special character
        cfg_spec_en = 1;
        rxc_data = 8'h7E; rxc_valid = 1; #2;
        chk("R9 special pushed", rxc_push, 1);
        tick(); rxc_valid = 0;
        chk("R9 hit", spec_hit, 1);
        tick(); chk("R9 one cycle", spec_hit, 0);
        rxc_data = 8'h7F; rxc_valid = 1; tick(); rxc_valid = 0;
        chk("R9 no match", spec_hit, 0);
        cfg_spec_en = 0;
        rxc_data = 8'h7E; rxc_valid = 1; tick(); rxc_valid = 0;
        chk("R9 disabled", spec_hit, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule